// File: doc/BRIEF.md
# Parallel flash configuration loader

This block is the master side of a byte-wide configuration load from a parallel NOR flash. A rising edge on the init input captures the mode, chip-select and read/write inputs. A valid mode picks ascending or descending addressing. The block then drives the flash address and control lines, generates a configuration clock and samples one data byte per address cycle. It hands each byte to downstream logic over a valid/ready stream.

The configuration clock is derived from the system clock by a divider. It starts at a slow initial rate set by a parameter. The first address is held for a stretched cycle so a slow flash can settle. Once the downstream consumer has found the rate setting in the stream, it writes a 4-bit rate code and the clock moves to the new rate at the next period boundary. The consumer asserts an end-of-load input when the image is complete. The block then releases the bus and raises a done flag. An unusable mode, or an address that would wrap, raises an error flag instead.

Top module: `flashCfgLoader`

## Requirements
- R1: While reset is asserted and afterwards until a load starts, the address output is 0, lowCtl is 3'b111, highCtl is 0, cfgClk is 0, byteValid is 0, and both loadDone and loadErr are 0.
- R2: modeIn, csN and rwIn are looked at only on a system clock edge where initIn is seen rising while no load is running. Changes to them, and further init rising edges during a load, have no effect on that load.
- R3: Mode 3'b010 (with csN low and rwIn high) starts an ascending load: the first address is 0, then 1, advancing by one per byte taken.
- R4: Mode 3'b011 (with csN low and rwIn high) starts a descending load from the all-ones address, stepping down by one per byte taken.
- R5: While a load runs, lowCtl is 3'b000 and highCtl is 1. The first byte is sampled on the (FIRST_CYC+1)-th rising cfgClk edge after the start, so the first address is held for more than FIRST_CYC full initial-rate periods.
- R6: cfgClk has a period of 2*INIT_HALF system clocks from the start of a load. After a rate write of code s while loading, every period that begins after the next falling cfgClk edge lasts 2*(s+1) system clocks.
- R7: After the first cycle, flashData is sampled on the rising cfgClk edge that ends each address cycle. The byte then appears on byteData with byteValid, held stable until byteReady is seen high.
- R8: When a rising cfgClk edge finds the previous byte still not accepted, nothing is sampled and the address is held for another period.
- R9: endLoad high during a load ends it on the next clock. loadDone goes to 1, and the address, control and clock outputs return to their R1 idle values.
- R10: An init rising edge with a mode other than 3'b010/3'b011, csN high or rwIn low sets loadErr, and no address cycle is started.
- R11: Taking the byte at the last address of the chosen direction (all-ones ascending, 0 descending) ends the load with loadErr set and the bus idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initIn | input | 1 | Init signal; its rising edge captures the mode and starts a load |
| modeIn | input | 3 | Mode selection, captured on the init rising edge |
| csN | input | 1 | Active-low select, must be low at the init edge |
| rwIn | input | 1 | Read request, must be high at the init edge |
| flashData | input | DATA_W | Data byte from the flash |
| byteReady | input | 1 | Downstream accepts the presented byte |
| rateWe | input | 1 | Write strobe for the clock rate code |
| rateSel | input | RATE_W | New rate code; half period becomes rateSel+1 system clocks |
| endLoad | input | 1 | Downstream signals that the image is complete |
| flashAddr | output | ADDR_W | Flash address, 0 when idle |
| lowCtl | output | 3 | Active-low flash enable lines, 3'b000 while loading |
| highCtl | output | 1 | High-side control, 1 while loading |
| cfgClk | output | 1 | Configuration clock |
| byteData | output | DATA_W | Captured byte |
| byteValid | output | 1 | byteData holds an unaccepted byte |
| loadDone | output | 1 | Load ended normally |
| loadErr | output | 1 | Bad mode at start, or address wrap |

## Verification
The hardest state to reach is the address wrap of R11, because at the default width it needs millions of bytes. The bench builds the loader with a 5-bit address and selects the fastest rate code after the first byte, so a descending load runs off address 0 within a few hundred cycles. The second hard case is a rising cfgClk edge that lands while a byte is still unaccepted. byteReady is toggled on a three-cycle rhythm against an eight-cycle clock period, so stalls and clean takes both land on rising edges.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  localparam logic [2:0] MODE_ASC  = 3'b010;
  localparam logic [2:0] MODE_DESC = 3'b011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_READ,
    ST_DONE,
    ST_FAULT
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // start a new load, set start address
    logic descend;  // direction taken with load
    logic capture;  // sample data, advance address
  } ctlStrobe_t;

endpackage

// File: rtl/flashCfgClkDiv.sv
module flashCfgClkDiv #(
  parameter int INIT_HALF = 8,
  parameter int RATE_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              run,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateSel,
  output logic              clkReg,
  output logic              riseTick
);

  localparam int MAX_HALF = (INIT_HALF > (1 << RATE_W)) ? INIT_HALF : (1 << RATE_W);
  localparam int HALF_W   = $clog2(MAX_HALF + 1);
  localparam logic [HALF_W-1:0] INIT_H = HALF_W'(INIT_HALF);

  logic [HALF_W-1:0] halfCur;
  logic [HALF_W-1:0] halfPend;
  logic [HALF_W-1:0] cnt;
  logic              terminal;

  assign terminal = (cnt == halfCur - 1'b1);
  assign riseTick = run && terminal && !clkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      clkReg   <= 1'b0;
      halfCur  <= INIT_H;
      halfPend <= INIT_H;
    end else if (restart) begin
      cnt      <= '0;
      clkReg   <= 1'b0;
      halfCur  <= INIT_H;
      halfPend <= INIT_H;
    end else begin
      if (run && rateWe) begin
        halfPend <= HALF_W'(rateSel) + 1'b1;
      end
      if (!run) begin
        cnt    <= '0;
        clkReg <= 1'b0;
      end else if (terminal) begin
        cnt    <= '0;
        clkReg <= ~clkReg;
        // new rate only at a period boundary (falling edge)
        if (clkReg) begin
          halfCur <= halfPend;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flashCfgPath.sv
module flashCfgPath
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] flashData,
  input  logic              byteReady,
  output logic [ADDR_W-1:0] addrReg,
  output logic              atLast,
  output logic [DATA_W-1:0] byteData,
  output logic              byteValid
);

  logic dirDown;

  assign atLast = dirDown ? (addrReg == '0) : (addrReg == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      dirDown   <= 1'b0;
      byteData  <= '0;
      byteValid <= 1'b0;
    end else if (strobe.load) begin
      dirDown   <= strobe.descend;
      addrReg   <= strobe.descend ? '1 : '0;
      byteValid <= 1'b0;
    end else if (strobe.capture) begin
      byteData  <= flashData;
      byteValid <= 1'b1;
      addrReg   <= dirDown ? addrReg - 1'b1 : addrReg + 1'b1;
    end else if (byteValid && byteReady) begin
      byteValid <= 1'b0;
    end
  end

endmodule

// File: rtl/flashCfgCtrl.sv
module flashCfgCtrl
  import flash_cfg_pkg::*;
#(
  parameter int FIRST_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initIn,
  input  logic [2:0] modeIn,
  input  logic       csN,
  input  logic       rwIn,
  input  logic       endLoad,
  input  logic       riseTick,
  input  logic       atLast,
  input  logic       byteValid,
  input  logic       byteReady,
  output ctlStrobe_t strobe,
  output logic       active,
  output logic       doneFlag,
  output logic       errFlag
);

  localparam int FC_W = $clog2(FIRST_CYC + 1);

  loadState_t      state;
  loadState_t      nextState;
  logic            initQ;
  logic            initRise;
  logic            modeOk;
  logic [FC_W-1:0] firstCnt;

  assign initRise = initIn && !initQ;
  assign active   = (state == ST_FIRST) || (state == ST_READ);
  assign doneFlag = (state == ST_DONE);
  assign errFlag  = (state == ST_FAULT);
  assign modeOk   = ((modeIn == MODE_ASC) || (modeIn == MODE_DESC)) && !csN && rwIn;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (active && endLoad) begin
      nextState = ST_DONE;
    end else if (!active && initRise) begin
      if (modeOk) begin
        strobe.load    = 1'b1;
        strobe.descend = modeIn[0];
        nextState      = ST_FIRST;
      end else begin
        nextState = ST_FAULT;
      end
    end else if (state == ST_FIRST && riseTick && firstCnt == FC_W'(FIRST_CYC)) begin
      strobe.capture = 1'b1;
    end else if (state == ST_READ && riseTick && (!byteValid || byteReady)) begin
      strobe.capture = 1'b1;
    end
    if (strobe.capture) begin
      nextState = atLast ? ST_FAULT : ST_READ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      initQ    <= 1'b0;
      firstCnt <= '0;
    end else begin
      state <= nextState;
      initQ <= initIn;
      if (strobe.load) begin
        firstCnt <= '0;
      end else if (state == ST_FIRST && riseTick) begin
        firstCnt <= firstCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flashCfgLoader.sv
module flashCfgLoader
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int INIT_HALF = 8,
  parameter int FIRST_CYC = 5,
  parameter int RATE_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initIn,
  input  logic [2:0]        modeIn,
  input  logic              csN,
  input  logic              rwIn,
  input  logic [DATA_W-1:0] flashData,
  input  logic              byteReady,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              endLoad,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [2:0]        lowCtl,
  output logic              highCtl,
  output logic              cfgClk,
  output logic [DATA_W-1:0] byteData,
  output logic              byteValid,
  output logic              loadDone,
  output logic              loadErr
);

  ctlStrobe_t        strobe;
  logic              active;
  logic              riseTick;
  logic              clkReg;
  logic              atLast;
  logic [ADDR_W-1:0] addrReg;

  flashCfgCtrl #(.FIRST_CYC(FIRST_CYC)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .initIn    (initIn),
    .modeIn    (modeIn),
    .csN       (csN),
    .rwIn      (rwIn),
    .endLoad   (endLoad),
    .riseTick  (riseTick),
    .atLast    (atLast),
    .byteValid (byteValid),
    .byteReady (byteReady),
    .strobe    (strobe),
    .active    (active),
    .doneFlag  (loadDone),
    .errFlag   (loadErr)
  );

  flashCfgClkDiv #(.INIT_HALF(INIT_HALF), .RATE_W(RATE_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (strobe.load),
    .run      (active),
    .rateWe   (rateWe),
    .rateSel  (rateSel),
    .clkReg   (clkReg),
    .riseTick (riseTick)
  );

  flashCfgPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flashData (flashData),
    .byteReady (byteReady),
    .addrReg   (addrReg),
    .atLast    (atLast),
    .byteData  (byteData),
    .byteValid (byteValid)
  );

  assign flashAddr = active ? addrReg : '0;
  assign lowCtl    = active ? 3'b000 : 3'b111;
  assign highCtl   = active;
  assign cfgClk    = clkReg && active;

endmodule

// File: rtl/flashCfgChecker.sv
module flashCfgChecker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteReady,
  input logic              endLoad,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [2:0]        lowCtl,
  input logic              highCtl,
  input logic              cfgClk,
  input logic [DATA_W-1:0] byteData,
  input logic              byteValid,
  input logic              loadDone,
  input logic              loadErr
);

  logic activeNow;
  assign activeNow = (lowCtl == 3'b000);

  AST_IDLE_WHEN_FINISHED: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone || loadErr) |-> (flashAddr == '0 && lowCtl == 3'b111 && !highCtl && !cfgClk)); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadErr)); // R10

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && byteValid && !byteReady) |=> ((byteValid && $stable(byteData)) || !activeNow)); // R7

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && byteValid && !byteReady) |=> ($stable(flashAddr) || !activeNow)); // R8

  AST_ADDR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && $past(activeNow) && flashAddr != $past(flashAddr)) |->
      (flashAddr == $past(flashAddr) + 1'b1 || flashAddr == $past(flashAddr) - 1'b1)); // R3

  AST_CLK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> (activeNow && highCtl)); // R5

  AST_END_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && endLoad) |=> loadDone); // R9

endmodule

bind flashCfgLoader flashCfgChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .byteReady (byteReady),
  .endLoad   (endLoad),
  .flashAddr (flashAddr),
  .lowCtl    (lowCtl),
  .highCtl   (highCtl),
  .cfgClk    (cfgClk),
  .byteData  (byteData),
  .byteValid (byteValid),
  .loadDone  (loadDone),
  .loadErr   (loadErr)
);

// File: tb/tb_flashCfgLoader.sv
module tb_flashCfgLoader;

  localparam int AW = 5;
  localparam int DW = 8;
  localparam int IH = 8;
  localparam int FC = 5;
  localparam int RW = 4;
  localparam int MAXA = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initIn = 1'b0;
  logic [2:0]    modeIn = 3'b000;
  logic          csN = 1'b1;
  logic          rwIn = 1'b0;
  logic          byteReady = 1'b0;
  logic          rateWe = 1'b0;
  logic [RW-1:0] rateSel = '0;
  logic          endLoad = 1'b0;
  logic [DW-1:0] flashData;
  logic [AW-1:0] flashAddr;
  logic [2:0]    lowCtl;
  logic          highCtl;
  logic          cfgClk;
  logic [DW-1:0] byteData;
  logic          byteValid;
  logic          loadDone;
  logic          loadErr;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] flashFn(input int a);
    return DW'((a * 37) ^ 8'h5A);
  endfunction

  assign flashData = flashFn(int'(flashAddr));

  flashCfgLoader #(.ADDR_W(AW), .DATA_W(DW), .INIT_HALF(IH), .FIRST_CYC(FC), .RATE_W(RW)) dut (
    .clk(clk), .rstN(rstN), .initIn(initIn), .modeIn(modeIn), .csN(csN), .rwIn(rwIn),
    .flashData(flashData), .byteReady(byteReady), .rateWe(rateWe), .rateSel(rateSel),
    .endLoad(endLoad), .flashAddr(flashAddr), .lowCtl(lowCtl), .highCtl(highCtl),
    .cfgClk(cfgClk), .byteData(byteData), .byteValid(byteValid), .loadDone(loadDone),
    .loadErr(loadErr)
  );

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  // behavioural reference: 0 idle, 1 first cycle, 2 reading, 3 done, 4 fault
  int    mState = 0;
  int    mAddr = 0;
  bit    mDown = 0;
  int    mHalf = IH;
  int    mPend = IH;
  int    mCnt = 0;
  bit    mClk = 0;
  int    mFirst = 0;
  bit    mValid = 0;
  int    mByte = 0;
  bit    mInitQ = 0;
  string mErrTag = "R10";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycle);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    bit act, initRise, rise, cap, load, atLast;
    int ns, newPend, expAddr;
    cycle++;
    if (cycle > 100000) begin
      chk(0, "R1", "watchdog expired", cycle, 100000);
      summary();
    end
    act = (mState == 1) || (mState == 2);
    expAddr = act ? mAddr : 0;
    chk(int'(flashAddr) == expAddr, mDown ? "R4" : "R3", "address", int'(flashAddr), expAddr);
    chk(int'(lowCtl) == (act ? 0 : 7), "R5", "lowCtl", int'(lowCtl), act ? 0 : 7);
    chk(highCtl == act, "R5", "highCtl", int'(highCtl), int'(act));
    chk(cfgClk == (mClk && act), "R6", "cfgClk", int'(cfgClk), int'(mClk && act));
    chk(byteValid == mValid, "R8", "byteValid", int'(byteValid), int'(mValid));
    if (mValid) chk(int'(byteData) == mByte, "R7", "byteData", int'(byteData), mByte);
    chk(loadDone == (mState == 3), "R9", "loadDone", int'(loadDone), int'(mState == 3));
    chk(loadErr == (mState == 4), mErrTag, "loadErr", int'(loadErr), int'(mState == 4));

    if (!rstN) begin
      mState = 0; mAddr = 0; mDown = 0; mHalf = IH; mPend = IH; mCnt = 0;
      mClk = 0; mFirst = 0; mValid = 0; mByte = 0; mInitQ = 0;
    end else begin
      // predict the coming edge from the inputs held across it
      initRise = initIn && !mInitQ;
      mInitQ = initIn;
      rise = act && (mCnt == mHalf - 1) && !mClk;
      atLast = mDown ? (mAddr == 0) : (mAddr == MAXA);
      cap = 0; load = 0; ns = mState;
      if (act && endLoad) ns = 3;
      else if (!act && initRise) begin
        if ((modeIn == 3'b010 || modeIn == 3'b011) && !csN && rwIn) begin
          load = 1; ns = 1;
        end else begin
          ns = 4; mErrTag = "R10";
        end
      end else if (mState == 1 && rise && mFirst == FC) cap = 1;
      else if (mState == 2 && rise && (!mValid || byteReady)) cap = 1;
      if (cap) begin
        ns = atLast ? 4 : 2;
        if (atLast) mErrTag = "R11";
      end
      if (load) begin
        mCnt = 0; mClk = 0; mHalf = IH; mPend = IH; mFirst = 0;
        mDown = modeIn[0]; mAddr = modeIn[0] ? MAXA : 0; mValid = 0;
      end else begin
        newPend = (act && rateWe) ? int'(rateSel) + 1 : mPend;
        if (!act) begin
          mCnt = 0; mClk = 0;
        end else if (mCnt == mHalf - 1) begin
          mCnt = 0;
          if (mClk) mHalf = mPend;
          mClk = !mClk;
        end else mCnt++;
        mPend = newPend;
        if (mState == 1 && rise) mFirst++;
        if (cap) begin
          mByte = int'(flashFn(mAddr)); mValid = 1;
          mAddr = mDown ? ((mAddr + MAXA) & MAXA) : ((mAddr + 1) & MAXA);
        end else if (mValid && byteReady) mValid = 0;
      end
      mState = ns;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic startLoad(input logic [2:0] m, input logic cs, input logic rw);
    initIn = 1'b0;
    tick(1);
    modeIn = m; csN = cs; rwIn = rw;
    tick(1);
    initIn = 1'b1;
    tick(1);
  endtask

  initial begin
    int a1;
    tick(3);
    // R1: idle outputs out of reset
    chk(flashAddr == '0 && lowCtl == 3'b111 && !highCtl && !cfgClk, "R1", "idle after reset",
        int'(lowCtl), 7);
    rstN = 1'b1;
    tick(3);
    chk(!loadDone && !loadErr && !byteValid, "R1", "flags after reset", int'(loadErr), 0);

    // R3/R5: ascending load, slow first cycle, bytes taken at once
    byteReady = 1'b1;
    startLoad(3'b010, 1'b0, 1'b1);
    tick(200);
    // R6: switch to half period 4
    rateWe = 1'b1; rateSel = 4'd3;
    tick(1);
    rateWe = 1'b0;
    // R2: new mode and another init rise mid-load are ignored
    a1 = int'(flashAddr);
    modeIn = 3'b011; initIn = 1'b0;
    tick(2);
    initIn = 1'b1;
    tick(20);
    chk(int'(flashAddr) > a1 && lowCtl == 3'b000, "R2", "direction kept after mid-load init",
        int'(flashAddr), a1 + 1);
    // R8: long stall, then ready toggled against the clock period
    byteReady = 1'b0;
    tick(40);
    for (int k = 0; k < 30; k++) begin
      byteReady = ~byteReady;
      tick(3);
    end
    byteReady = 1'b1;
    tick(10);
    // R9: end of load
    endLoad = 1'b1;
    tick(1);
    endLoad = 1'b0;
    tick(5);
    chk(loadDone && flashAddr == '0 && lowCtl == 3'b111, "R9", "done with bus released",
        int'(loadDone), 1);

    // R4/R11: descending load run to the wrap at address 0
    startLoad(3'b011, 1'b0, 1'b1);
    tick(110);
    rateWe = 1'b1; rateSel = 4'd0;
    tick(1);
    rateWe = 1'b0;
    tick(200);
    chk(loadErr && !loadDone, "R11", "wrap raises error", int'(loadErr), 1);

    // R10: bad mode, chip select high, write request
    startLoad(3'b001, 1'b0, 1'b1);
    tick(40);
    chk(loadErr && flashAddr == '0 && !cfgClk, "R10", "bad mode does not read", int'(loadErr), 1);
    startLoad(3'b010, 1'b1, 1'b1);
    tick(10);
    chk(loadErr && lowCtl == 3'b111, "R10", "chip select high refused", int'(lowCtl), 7);
    startLoad(3'b011, 1'b0, 1'b0);
    tick(10);
    chk(loadErr && lowCtl == 3'b111, "R10", "write request refused", int'(lowCtl), 7);

    // R5/R9: restart from fault, end during the stretched first cycle
    startLoad(3'b010, 1'b0, 1'b1);
    tick(30);
    chk(!byteValid && lowCtl == 3'b000 && flashAddr == '0, "R5", "first address still held",
        int'(flashAddr), 0);
    endLoad = 1'b1;
    tick(1);
    endLoad = 1'b0;
    tick(3);
    chk(loadDone && !loadErr, "R9", "end during first cycle", int'(loadDone), 1);
    summary();
  end

endmodule